// File: doc/BRIEF.md
# DMA Channel Loop Sequencer

This block sequences the addresses and counts for a single DMA channel. It holds a descriptor: source and destination addresses, signed per-access offsets, a byte count per inner (minor) loop, current and reload major iteration counts, signed end-of-major address corrections, access width codes and a 16-bit control/status word. Each service request runs one minor loop. A minor loop is a series of read/write beat pairs on a simple valid/ready memory request port. When the minor loop ends, the block steps the major count and updates its flags, and it can raise a mid-point or a completion interrupt pulse.

A minor loop begins in one of two ways. Software can set the start bit, either through the descriptor load or through a one-cycle start pulse. A hardware request line also begins one when the channel's request enable is set. A request arbiter, descriptor chaining and channel linking sit outside this block.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset no beat is issued, the control word, request enable, iteration count and both interrupt outputs are zero.
- R2: A set start bit (control bit 0, from the descriptor load or `sw_start`) begins one minor loop. In the cycle after the begin, the active bit (bit 6) is 1 and bit 0 is 0. Bit 6 returns to 0 when the minor loop ends.
- R3: While `req_en` is 0, a pulse on `hw_req` has no effect: no beat is issued and the active bit stays 0. While `req_en` is 1, a pulse begins a minor loop.
- R4: A minor loop issues P read/write pairs. P is the byte count divided by the source width, with a minimum of 1. Each read (`mem_write`=0) carries the source width code and each write carries the destination width code. Width codes are 0=1, 1=2, 2=4, 3=8 and 5=32 bytes; any other code counts as 1 byte. A beat is accepted when `mem_valid` and `mem_ready` are both high at a clock edge, and it holds its address until then.
- R5: After each accepted read, the source address moves by the signed 16-bit source offset. After each accepted write, the destination address moves by the signed 16-bit destination offset.
- R6: Each minor loop lowers the current count by one. A minor loop that begins with a count of 1 completes the major loop. Completion reloads the count from the reload value, adds the signed last-source and last-destination corrections, and sets the done bit (bit 7).
- R7: If control bit 1 is set, a completing minor loop pulses `irq_major` for exactly one cycle, in the same cycle that done is set. If bit 1 is clear, there is no pulse.
- R8: If control bit 2 is set, `irq_half` pulses for one cycle when a non-completing minor loop leaves the count equal to the reload value shifted right by one. It never fires when the reload value is 1.
- R9: If control bit 3 is set, completion clears `req_en`, and later `hw_req` pulses are then ignored.
- R10: Control bits 15:14 set the idle gap after each accepted write: 2 gives 4 cycles, 3 gives 8 cycles, and 0 or 1 gives none. Without a gap, the next read follows the write in the next cycle.
- R11: A descriptor load (`cfg_wr`) while a minor loop is running is ignored.
- R12: The done bit is cleared when the next minor loop begins, so done and active are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load descriptor (idle only) |
| cfg_saddr | input | AW | Source address |
| cfg_daddr | input | AW | Destination address |
| cfg_soff | input | 16 | Signed source offset |
| cfg_doff | input | 16 | Signed destination offset |
| cfg_ssize | input | 3 | Source width code |
| cfg_dsize | input | 3 | Destination width code |
| cfg_nbytes | input | NBW | Bytes per minor loop |
| cfg_slast | input | AW | Signed source correction at completion |
| cfg_dlast | input | AW | Signed destination correction at completion |
| cfg_biter | input | CW | Major iteration reload value |
| cfg_ctrl | input | 16 | Control word (bits 6 and 7 ignored on load) |
| req_en_set | input | 1 | Set the request enable |
| hw_req | input | 1 | Hardware service request |
| sw_start | input | 1 | Set the start bit |
| mem_valid | output | 1 | Beat request valid |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat address |
| mem_size | output | 3 | Beat width code |
| mem_ready | input | 1 | Beat accepted |
| cur_saddr | output | AW | Current source address |
| cur_daddr | output | AW | Current destination address |
| cur_iter | output | CW | Current major iteration count |
| ctrl_word | output | 16 | Control/status word |
| req_en | output | 1 | Hardware request enable |
| irq_major | output | 1 | Completion interrupt pulse |
| irq_half | output | 1 | Mid-point interrupt pulse |

## Verification
Positive offsets with a reload count of 3 show that the count steps, the corrections apply and done is set only on the last loop. Negative offsets of two sizes, with a reload count of 1 and a stalling memory, separate signed from unsigned address steps and show that every loop completes with no mid-point pulse. Reload counts of 4, different width codes and byte counts below one access distinguish the mid-point rule and the pair-count rule. The three gap settings, the request-enable gating and a descriptor write during a running loop each show up in beat timing or beat addresses that differ from the reference model.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WR    = 3'd2,
        ST_STALL = 3'd3,
        ST_FIN   = 3'd4
    } dlp_state_e;

    // control word bit positions
    localparam int CB_START     = 0;
    localparam int CB_INT_MAJOR = 1;
    localparam int CB_INT_HALF  = 2;
    localparam int CB_CLR_REQ   = 3;
    localparam int CB_ACTIVE    = 6;
    localparam int CB_DONE      = 7;
    localparam int CB_BW_LO     = 14;

    // width code to log2 of bytes per access
    function automatic logic [2:0] size_log2(input logic [2:0] code);
        case (code)
            3'd1:    return 3'd1;
            3'd2:    return 3'd2;
            3'd3:    return 3'd3;
            3'd5:    return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dlp_pair_calc.sv
module dlp_pair_calc #(
    parameter int NBW = 16
) (
    input  logic [NBW-1:0] nbytes,
    input  logic [2:0]     ssize,
    output logic [NBW-1:0] pairs
);
    import dlp_pkg::*;

    logic [NBW-1:0] shifted;

    always_comb begin
        shifted = nbytes >> size_log2(ssize);
        pairs   = (shifted == '0) ? {{(NBW-1){1'b0}}, 1'b1} : shifted;
    end
endmodule

// File: rtl/dlp_stall_sel.sv
module dlp_stall_sel #(
    parameter int STALL_SHORT = 4,
    parameter int STALL_LONG  = 8,
    parameter int SCW         = 4
) (
    input  logic [1:0]     bw_code,
    output logic [SCW-1:0] stall_len
);
    always_comb begin
        case (bw_code)
            2'd2:    stall_len = SCW'(STALL_SHORT);
            2'd3:    stall_len = SCW'(STALL_LONG);
            default: stall_len = '0;
        endcase
    end
endmodule

// File: rtl/dlp_iter_step.sv
module dlp_iter_step #(
    parameter int CW = 15
) (
    input  logic [CW-1:0] citer,
    input  logic [CW-1:0] biter,
    input  logic          half_en,
    output logic [CW-1:0] next_iter,
    output logic          complete,
    output logic          half_hit
);
    logic [CW-1:0] dec;

    always_comb begin
        dec       = citer - {{(CW-1){1'b0}}, 1'b1};
        complete  = (citer <= {{(CW-1){1'b0}}, 1'b1});
        next_iter = complete ? biter : dec;
        half_hit  = half_en && !complete && (dec == (biter >> 1));
    end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine #(
    parameter int AW          = 32,
    parameter int NBW         = 16,
    parameter int CW          = 15,
    parameter int STALL_SHORT = 4,
    parameter int STALL_LONG  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [AW-1:0]  cfg_saddr,
    input  logic [AW-1:0]  cfg_daddr,
    input  logic [15:0]    cfg_soff,
    input  logic [15:0]    cfg_doff,
    input  logic [2:0]     cfg_ssize,
    input  logic [2:0]     cfg_dsize,
    input  logic [NBW-1:0] cfg_nbytes,
    input  logic [AW-1:0]  cfg_slast,
    input  logic [AW-1:0]  cfg_dlast,
    input  logic [CW-1:0]  cfg_biter,
    input  logic [15:0]    cfg_ctrl,
    input  logic           req_en_set,
    input  logic           hw_req,
    input  logic           sw_start,
    output logic           mem_valid,
    output logic           mem_write,
    output logic [AW-1:0]  mem_addr,
    output logic [2:0]     mem_size,
    input  logic           mem_ready,
    output logic [AW-1:0]  cur_saddr,
    output logic [AW-1:0]  cur_daddr,
    output logic [CW-1:0]  cur_iter,
    output logic [15:0]    ctrl_word,
    output logic           req_en,
    output logic           irq_major,
    output logic           irq_half
);
    import dlp_pkg::*;

    localparam int EXT = AW - 16;
    localparam int SCW = $clog2(STALL_LONG + 1);

    typedef struct packed {
        dlp_state_e     st;
        logic [AW-1:0]  saddr;
        logic [AW-1:0]  daddr;
        logic [AW-1:0]  slast;
        logic [AW-1:0]  dlast;
        logic [15:0]    soff;
        logic [15:0]    doff;
        logic [2:0]     ssize;
        logic [2:0]     dsize;
        logic [NBW-1:0] nbytes;
        logic [NBW-1:0] pairs;
        logic [CW-1:0]  citer;
        logic [CW-1:0]  biter;
        logic [15:0]    ctrl;
        logic [SCW-1:0] stall;
        logic           req_en;
        logic           irq_major;
        logic           irq_half;
    } regs_t;

    regs_t r_d, r_q;

    logic [NBW-1:0] pair_cnt;
    logic [SCW-1:0] stall_len;
    logic [CW-1:0]  iter_next;
    logic           iter_done, iter_half;
    logic           begin_loop;

    dlp_pair_calc #(.NBW(NBW)) u_pairs (
        .nbytes (r_q.nbytes),
        .ssize  (r_q.ssize),
        .pairs  (pair_cnt)
    );

    dlp_stall_sel #(.STALL_SHORT(STALL_SHORT), .STALL_LONG(STALL_LONG), .SCW(SCW)) u_stall (
        .bw_code   (r_q.ctrl[CB_BW_LO+1:CB_BW_LO]),
        .stall_len (stall_len)
    );

    dlp_iter_step #(.CW(CW)) u_iter (
        .citer     (r_q.citer),
        .biter     (r_q.biter),
        .half_en   (r_q.ctrl[CB_INT_HALF]),
        .next_iter (iter_next),
        .complete  (iter_done),
        .half_hit  (iter_half)
    );

    assign begin_loop = r_q.ctrl[CB_START] || sw_start || (hw_req && r_q.req_en);

    always_comb begin
        r_d           = r_q;
        r_d.irq_major = 1'b0;
        r_d.irq_half  = 1'b0;
        if (req_en_set) r_d.req_en = 1'b1;
        if (sw_start)   r_d.ctrl[CB_START] = 1'b1;

        case (r_q.st)
            ST_IDLE: begin
                if (cfg_wr) begin
                    r_d.saddr  = cfg_saddr;
                    r_d.daddr  = cfg_daddr;
                    r_d.soff   = cfg_soff;
                    r_d.doff   = cfg_doff;
                    r_d.ssize  = cfg_ssize;
                    r_d.dsize  = cfg_dsize;
                    r_d.nbytes = cfg_nbytes;
                    r_d.slast  = cfg_slast;
                    r_d.dlast  = cfg_dlast;
                    r_d.biter  = cfg_biter;
                    r_d.citer  = cfg_biter;
                    r_d.ctrl   = cfg_ctrl;
                    r_d.ctrl[CB_ACTIVE] = 1'b0;
                    r_d.ctrl[CB_DONE]   = 1'b0;
                end else if (begin_loop) begin
                    r_d.st              = ST_RD;
                    r_d.pairs           = pair_cnt;
                    r_d.ctrl[CB_START]  = 1'b0;
                    r_d.ctrl[CB_ACTIVE] = 1'b1;
                    r_d.ctrl[CB_DONE]   = 1'b0;
                end
            end
            ST_RD: begin
                if (mem_ready) begin
                    r_d.saddr = r_q.saddr + {{EXT{r_q.soff[15]}}, r_q.soff};
                    r_d.st    = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    r_d.daddr = r_q.daddr + {{EXT{r_q.doff[15]}}, r_q.doff};
                    r_d.pairs = r_q.pairs - 1'b1;
                    if (stall_len != '0) begin
                        r_d.st    = ST_STALL;
                        r_d.stall = stall_len;
                    end else begin
                        r_d.st = (r_q.pairs == {{(NBW-1){1'b0}}, 1'b1}) ? ST_FIN : ST_RD;
                    end
                end
            end
            ST_STALL: begin
                r_d.stall = r_q.stall - 1'b1;
                if (r_q.stall == {{(SCW-1){1'b0}}, 1'b1})
                    r_d.st = (r_q.pairs == '0) ? ST_FIN : ST_RD;
            end
            ST_FIN: begin
                r_d.st              = ST_IDLE;
                r_d.citer           = iter_next;
                r_d.ctrl[CB_ACTIVE] = 1'b0;
                r_d.irq_half        = iter_half;
                if (iter_done) begin
                    r_d.saddr         = r_q.saddr + r_q.slast;
                    r_d.daddr         = r_q.daddr + r_q.dlast;
                    r_d.ctrl[CB_DONE] = 1'b1;
                    r_d.irq_major     = r_q.ctrl[CB_INT_MAJOR];
                    if (r_q.ctrl[CB_CLR_REQ]) r_d.req_en = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_valid = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign mem_write = (r_q.st == ST_WR);
    assign mem_addr  = mem_write ? r_q.daddr : r_q.saddr;
    assign mem_size  = mem_write ? r_q.dsize : r_q.ssize;
    assign cur_saddr = r_q.saddr;
    assign cur_daddr = r_q.daddr;
    assign cur_iter  = r_q.citer;
    assign ctrl_word = r_q.ctrl;
    assign req_en    = r_q.req_en;
    assign irq_major = r_q.irq_major;
    assign irq_half  = r_q.irq_half;

endmodule

// File: rtl/dlp_checker.sv
module dlp_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   ctrl_word,
    input logic          req_en,
    input logic          irq_major,
    input logic          irq_half
);
    // beats only while the active flag is up (R2)
    p_beat_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ctrl_word[6]);

    // a stalled beat holds its address (R4)
    p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // completion pulse comes with done and lasts one cycle (R7)
    p_major_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_major |-> ctrl_word[7]);
    p_major_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_major |=> !irq_major);

    // mid-point pulse only when enabled (R8)
    p_half_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half |-> ctrl_word[2]);

    // completion with clear-request option drops the enable (R9)
    p_req_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_word[7]) && ctrl_word[3]) |-> !req_en);

    // done and active never together (R12)
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[7] |-> !ctrl_word[6]);
endmodule

bind dma_loop_engine dlp_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .ctrl_word (ctrl_word),
    .req_en    (req_en),
    .irq_major (irq_major),
    .irq_half  (irq_half)
);

// File: tb/dma_loop_engine_test.sv
module dma_loop_engine_test;
    localparam int AW = 32, NBW = 16, CW = 15;

    logic clk = 0, rst_n = 0;
    logic cfg_wr = 0;
    logic [AW-1:0] cfg_saddr = '0, cfg_daddr = '0, cfg_slast = '0, cfg_dlast = '0;
    logic [15:0] cfg_soff = '0, cfg_doff = '0, cfg_ctrl = '0;
    logic [2:0] cfg_ssize = '0, cfg_dsize = '0;
    logic [NBW-1:0] cfg_nbytes = '0;
    logic [CW-1:0] cfg_biter = '0;
    logic req_en_set = 0, hw_req = 0, sw_start = 0, mem_ready = 1;
    logic mem_valid, mem_write, req_en, irq_major, irq_half;
    logic [AW-1:0] mem_addr, cur_saddr, cur_daddr;
    logic [2:0] mem_size;
    logic [CW-1:0] cur_iter;
    logic [15:0] ctrl_word;

    dma_loop_engine #(.AW(AW), .NBW(NBW), .CW(CW)) uut (.*);

    always #5 clk = ~clk;

    int n_checks = 0, n_err = 0;
    int cyc_n = 0, log_n = 0, n_major = 0, n_half = 0;
    bit ready_slow = 0;
    logic [31:0] log_addr [0:127];
    logic        log_wr   [0:127];
    logic [2:0]  log_size [0:127];
    int          log_cyc  [0:127];

    // descriptor shadow and reference model state
    logic [15:0] g_soff, g_doff, g_ctrl;
    logic [2:0]  g_ssize, g_dsize;
    int          g_nbytes;
    logic [31:0] g_slast, g_dlast;
    int          g_biter;
    logic [31:0] m_s, m_d;
    int          m_ci;

    always @(negedge clk) begin
        cyc_n++;
        if (mem_valid && mem_ready && log_n < 128) begin
            log_addr[log_n] = mem_addr;
            log_wr[log_n]   = mem_write;
            log_size[log_n] = mem_size;
            log_cyc[log_n]  = cyc_n;
            log_n++;
        end
        if (irq_major) n_major++;
        if (irq_half)  n_half++;
    end

    initial begin
        forever begin
            @(posedge clk);
            #2 mem_ready = ready_slow ? ((cyc_n % 3) != 0) : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wbytes(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd5: return 32;
            default: return 1;
        endcase
    endfunction

    task automatic load(input logic [31:0] sa, input logic [31:0] da,
                        input logic [15:0] so, input logic [15:0] dof,
                        input logic [2:0] ss, input logic [2:0] ds, input int nb,
                        input logic [31:0] sl, input logic [31:0] dl,
                        input int bi, input logic [15:0] ct);
        @(negedge clk);
        cfg_saddr = sa; cfg_daddr = da; cfg_soff = so; cfg_doff = dof;
        cfg_ssize = ss; cfg_dsize = ds; cfg_nbytes = NBW'(nb);
        cfg_slast = sl; cfg_dlast = dl; cfg_biter = CW'(bi); cfg_ctrl = ct;
        cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        g_soff = so; g_doff = dof; g_ssize = ss; g_dsize = ds; g_nbytes = nb;
        g_slast = sl; g_dlast = dl; g_biter = bi; g_ctrl = ct;
        m_s = sa; m_d = da; m_ci = bi;
    endtask

    task automatic run_minor(input bit use_hw, input bit poke);
        int pairs, maj0, half0, exp_half, exp_major;
        bit complete;
        pairs = g_nbytes / wbytes(g_ssize);
        if (pairs == 0) pairs = 1;
        log_n = 0; maj0 = n_major; half0 = n_half;
        @(negedge clk);
        if (use_hw) hw_req = 1; else sw_start = 1;
        @(negedge clk);
        hw_req = 0; sw_start = 0;
        chk(ctrl_word[6] == 1'b1, "R2", "active set at begin", ctrl_word[6], 1);
        chk(ctrl_word[0] == 1'b0, "R2", "start cleared at begin", ctrl_word[0], 0);
        chk(ctrl_word[7] == 1'b0, "R12", "done cleared at begin", ctrl_word[7], 0);
        if (poke) begin
            cfg_saddr = 32'hDEAD_0000; cfg_daddr = 32'hBEEF_0000; cfg_biter = 7;
            cfg_wr = 1;
            @(negedge clk);
            cfg_wr = 0;
        end
        while (ctrl_word[6]) @(negedge clk);
        @(negedge clk);
        chk(log_n == 2 * pairs, "R4", "beat count", log_n, 2 * pairs);
        for (int i = 0; i < pairs; i++) begin
            if (2 * i + 1 < log_n) begin
                chk(log_wr[2*i] == 0 && log_addr[2*i] == m_s && log_size[2*i] == g_ssize,
                    "R5", "read beat address", log_addr[2*i], m_s);
                chk(log_wr[2*i+1] == 1 && log_addr[2*i+1] == m_d && log_size[2*i+1] == g_dsize,
                    "R5", "write beat address", log_addr[2*i+1], m_d);
            end
            m_s = m_s + {{16{g_soff[15]}}, g_soff};
            m_d = m_d + {{16{g_doff[15]}}, g_doff};
        end
        complete  = (m_ci <= 1);
        exp_half  = 0;
        exp_major = 0;
        if (complete) begin
            m_ci = g_biter;
            m_s = m_s + g_slast;
            m_d = m_d + g_dlast;
            exp_major = g_ctrl[1] ? 1 : 0;
        end else begin
            m_ci = m_ci - 1;
            if (g_ctrl[2] && m_ci == g_biter / 2) exp_half = 1;
        end
        chk(cur_saddr == m_s, "R6", "source after loop", cur_saddr, m_s);
        chk(cur_daddr == m_d, "R6", "destination after loop", cur_daddr, m_d);
        chk(int'(cur_iter) == m_ci, "R6", "iteration count", cur_iter, m_ci);
        chk(ctrl_word[7] == complete, "R6", "done flag", ctrl_word[7], complete);
        chk(ctrl_word[6] == 1'b0, "R2", "active cleared at end", ctrl_word[6], 0);
        chk(n_major - maj0 == exp_major, "R7", "completion pulses", n_major - maj0, exp_major);
        chk(n_half - half0 == exp_half, "R8", "mid-point pulses", n_half - half0, exp_half);
    endtask

    task automatic t_reset;
        chk(!mem_valid, "R1", "no beat after reset", mem_valid, 0);
        chk(ctrl_word == 0, "R1", "control word", ctrl_word, 0);
        chk(!req_en && !irq_major && !irq_half, "R1", "enable and pulses",
            {req_en, irq_major, irq_half}, 0);
        chk(cur_iter == 0, "R1", "iteration count", cur_iter, 0);
    endtask

    task automatic t_basic;
        load(32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 16,
             -32'sd16, -32'sd16, 3, 16'h0002);
        for (int k = 0; k < 4; k++) run_minor(0, 0);
    endtask

    task automatic t_negative;
        ready_slow = 1;
        load(32'h8000, 32'h9000, 16'hFFFE, 16'hFFF8, 3'd1, 3'd3, 6,
             32'd100, -32'sd4, 1, 16'h0006);
        run_minor(0, 0);
        run_minor(0, 0);
        ready_slow = 0;
    endtask

    task automatic t_half;
        load(32'h0, 32'h400, 16'd1, 16'd2, 3'd0, 3'd1, 2,
             32'd0, 32'd0, 4, 16'h0004);
        for (int k = 0; k < 4; k++) run_minor(0, 0);
    endtask

    task automatic t_widths;
        load(32'h100, 32'h200, 16'd32, 16'd32, 3'd5, 3'd5, 64, 0, 0, 2, 16'h0000);
        run_minor(0, 0);
        load(32'h300, 32'h500, 16'd1, 16'd2, 3'd0, 3'd1, 3, 0, 0, 2, 16'h0000);
        run_minor(0, 0);
        load(32'h600, 32'h700, 16'd8, 16'd8, 3'd3, 3'd3, 4, 0, 0, 2, 16'h0000);
        run_minor(0, 0);
        // start bit through the descriptor load
        load(32'h800, 32'h900, 16'd4, 16'd4, 3'd2, 3'd2, 4, 0, 0, 2, 16'h0001);
        log_n = 0;
        repeat (6) @(negedge clk);
        chk(log_n == 2 && log_addr[0] == 32'h800, "R2", "start bit from load", log_addr[0], 32'h800);
    endtask

    task automatic t_stall;
        logic [15:0] codes [3] = '{16'h8000, 16'hC000, 16'h0000};
        int gaps [3] = '{5, 9, 1};
        for (int k = 0; k < 3; k++) begin
            load(32'hA00, 32'hB00, 16'd4, 16'd4, 3'd2, 3'd2, 8, 0, 0, 5, codes[k]);
            run_minor(0, 0);
            chk(log_cyc[1] - log_cyc[0] == 1, "R10", "read to write", log_cyc[1] - log_cyc[0], 1);
            chk(log_cyc[2] - log_cyc[1] == gaps[k], "R10", "write to next read",
                log_cyc[2] - log_cyc[1], gaps[k]);
        end
    endtask

    task automatic t_hwreq;
        load(32'hC00, 32'hD00, 16'd4, 16'd4, 3'd2, 3'd2, 8, 0, 0, 1, 16'h000A);
        log_n = 0;
        @(negedge clk); hw_req = 1; @(negedge clk); hw_req = 0;
        repeat (10) @(negedge clk);
        chk(log_n == 0 && !ctrl_word[6], "R3", "request ignored without enable", log_n, 0);
        chk(int'(cur_iter) == 1, "R3", "count untouched", cur_iter, 1);
        @(negedge clk); req_en_set = 1; @(negedge clk); req_en_set = 0;
        chk(req_en, "R3", "enable set", req_en, 1);
        run_minor(1, 0);
        chk(!req_en, "R9", "enable cleared at completion", req_en, 0);
        log_n = 0;
        @(negedge clk); hw_req = 1; @(negedge clk); hw_req = 0;
        repeat (10) @(negedge clk);
        chk(log_n == 0 && !ctrl_word[6], "R9", "request ignored after clear", log_n, 0);
    endtask

    task automatic t_busy;
        load(32'h4000, 32'h5000, 16'd1, 16'd1, 3'd0, 3'd0, 32, 0, 0, 3, 16'h0000);
        run_minor(0, 1);
        chk(int'(cur_iter) == 2, "R11", "load while busy ignored", cur_iter, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_negative;
        t_half;
        t_widths;
        t_stall;
        t_hwreq;
        t_busy;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule